// File: doc/BRIEF.md
# Card Identity SPI Read Responder

This block is the target side of a small SPI link. On each framed four-byte exchange it answers a host's read request on behalf of one of two card positions. Each position holds a 128-byte identity image and a presence flag. A host selects a position by writing an 8-bit select register. The first request byte is a command byte whose value is not checked. The second byte is an offset. During the third and fourth byte times the responder returns the image byte at that offset and the byte after it. During the first two byte times it returns zeros.

When the select register names no position, or the named position is marked absent, the responder returns a reply that looks like an empty device: every bit of the frame reads as one. A frame that starts with no usable select bit also raises a one-cycle error pulse. The images, the presence flags and the select register are loaded through a synchronous load port, and that port takes effect only between frames. The SPI pins are sampled through synchronisers in the system clock domain. The serial clock must therefore be much slower than `clk`: each SPI half period must be at least eight system clocks.

Top module: `spi_eep_responder`

## Requirements
- R1: After reset the select register is 0x00, both presence flags are clear, `err_pulse` is low and `spi_miso` is high.
- R2: A frame is the time `spi_cs_n` is low and covers four bytes in SPI mode 0. The bit order is MSB first. The host samples `spi_miso` on the rising edge of `spi_sclk`, and the first reply bit is valid before the first rising edge.
- R3: Target choice is a priority decode. When select bit 5 is set, position 0 is used. Otherwise, when select bit 3 is set, position 1 is used. Otherwise no position is used.
- R4: When no position is used, or the chosen position's presence flag is clear, all four reply bytes are 0xFF.
- R5: For a present target, the reply is 0x00, 0x00, image[offset], image[offset+1]. The offset is the second byte received in the frame.
- R6: The image is indexed by the low 7 bits of the offset, and bit 7 of the offset is ignored. The second data byte comes from address (offset+1) mod 128, so offset 127 is followed by address 0.
- R7: The value of the first request byte does not change the reply.
- R8: Raising `spi_cs_n` before the frame ends abandons the frame. The next frame starts again at byte 0.
- R9: `err_pulse` is high for exactly one clock at the start of a frame when neither select bit 5 nor select bit 3 is set. It stays low for every other frame.
- R10: The load port acts when `ld_en` is high, according to `ld_kind`. Kind 0 writes `ld_data` to image byte `ld_addr` of position `ld_pos`. Kind 1 sets that position's presence flag to `ld_data[0]`. Kind 2 writes `ld_data` to the select register. Kind 3 does nothing. All loads are ignored while `spi_cs_n` is low.
- R11: `spi_miso` is high while no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host, mode 0 |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Request data from the host |
| spi_miso | output | 1 | Reply data to the host |
| ld_en | input | 1 | Load port strobe |
| ld_kind | input | 2 | Load kind: 0 image byte, 1 presence, 2 select, 3 none |
| ld_pos | input | 1 | Card position for image and presence loads |
| ld_addr | input | 7 | Image byte address |
| ld_data | input | 8 | Load data |
| err_pulse | output | 1 | One-clock pulse for a frame started with no usable select |

## Verification
The hardest cases to reach from the ports are two. The first is a load attempted in the middle of a frame, which must leave no trace. The second is a frame abandoned partway through a byte, which must not disturb the next frame. To reach the first, the bench lowers the frame select, waits past the synchroniser, and writes both an image byte and the select register. It then reads that byte back in a later clean frame and expects the old value. To reach the second, the bench stops a frame after ten bits and follows it at once with a full read. It also reads at offset 127 to cover the address wrap, and uses an offset with bit 7 set.

// File: rtl/spi_eep_pkg.sv
// Shared types and constants for the card identity SPI responder.
// Assumes one 8-bit reply character per SPI byte time.
package spi_eep_pkg;
    typedef enum logic [1:0] {
        LD_BYTE = 2'd0,
        LD_PRES = 2'd1,
        LD_SEL  = 2'd2,
        LD_NONE = 2'd3
    } ld_kind_e;

    localparam int FRAME_BYTES = 4;

    typedef struct packed {
        logic ok;
        logic pos;
    } target_t;
endpackage

// File: rtl/spi_eep_sync.sv
// Brings the SPI pins into the clk domain and detects the edges of the
// serial clock and of the frame select.
// Assumes every SPI half period spans several clk periods.
module spi_eep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_raw,
    input  logic cs_n_raw,
    input  logic mosi_raw,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_start,
    output logic cs_low,
    output logic mosi_s
);
    localparam logic [2:0] RST_VAL = 3'b010; // {mosi, cs_n, sclk}

    logic [2:0] raw;
    logic [2:0] synced;
    logic       sclk_d;
    logic       cs_n_d;

    assign raw = {mosi_raw, cs_n_raw, sclk_raw};

    for (genvar i = 0; i < 3; i++) begin : gen_chain
        logic [STAGES-1:0] chain;
        // shift each pin through its synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], raw[i]};
        end
        assign synced[i] = chain[STAGES-1];
    end

    // keep the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_n_d <= 1'b1;
        end else begin
            sclk_d <= synced[0];
            cs_n_d <= synced[1];
        end
    end

    assign sclk_rise = synced[0] & ~sclk_d;
    assign sclk_fall = ~synced[0] & sclk_d;
    assign cs_start  = ~synced[1] & cs_n_d;
    assign cs_low    = ~synced[1];
    assign mosi_s    = synced[2];
endmodule

// File: rtl/spi_eep_shift.sv
// Mode 0 byte engine: samples the request on rising serial clock edges,
// shifts the reply out on falling edges, and counts bits and bytes.
// Assumes edge strobes are single-cycle and mutually exclusive.
module spi_eep_shift #(
    parameter int W     = 8,
    parameter int FRAME = 4,
    localparam int CW   = $clog2(W),
    localparam int BW   = $clog2(FRAME + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          cs_start,
    input  logic          cs_low,
    input  logic          mosi,
    input  logic [W-1:0]  tx_first,
    input  logic [W-1:0]  tx_next,
    output logic          miso_bit,
    output logic          rx_done,
    output logic [W-1:0]  rx_byte,
    output logic [BW-1:0] rx_idx,
    output logic [BW-1:0] load_idx
);
    logic [CW-1:0] bit_cnt;
    logic [BW-1:0] byte_cnt;
    logic [W-1:0]  rx_sh;
    logic [W-1:0]  tx_sh;

    // frame sequencing, receive shift and transmit shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            rx_sh    <= '0;
            tx_sh    <= '1;
            rx_done  <= 1'b0;
            rx_byte  <= '0;
            rx_idx   <= '0;
        end else begin
            rx_done <= 1'b0;
            if (cs_start) begin
                bit_cnt  <= '0;
                byte_cnt <= '0;
                tx_sh    <= tx_first;
            end else if (!cs_low) begin
                bit_cnt  <= '0;
                byte_cnt <= '0;
                tx_sh    <= '1;
            end else begin
                if (sclk_rise && (byte_cnt < BW'(FRAME))) begin
                    rx_sh <= {rx_sh[W-2:0], mosi};
                    if (bit_cnt == CW'(W - 1)) begin
                        bit_cnt  <= '0;
                        byte_cnt <= byte_cnt + 1'b1;
                        rx_done  <= 1'b1;
                        rx_byte  <= {rx_sh[W-2:0], mosi};
                        rx_idx   <= byte_cnt;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (sclk_fall) begin
                    if (bit_cnt == '0)
                        tx_sh <= (byte_cnt < BW'(FRAME)) ? tx_next : '1;
                    else
                        tx_sh <= {tx_sh[W-2:0], 1'b1};
                end
            end
        end
    end

    assign miso_bit = tx_sh[W-1];
    assign load_idx = byte_cnt;
endmodule

// File: rtl/spi_eep_store.sv
// Per-position image memories with presence flags and a registered read.
// Assumes writes arrive only between frames (gated by the caller).
module spi_eep_store #(
    parameter int W     = 8,
    parameter int DEPTH = 128,
    parameter int POS   = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = (POS > 1) ? $clog2(POS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_we,
    input  logic          pres_we,
    input  logic [PW-1:0] wr_pos,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [PW-1:0] rd_pos,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic [POS-1:0] present
);
    logic [W-1:0] rd_all [POS];

    for (genvar p = 0; p < POS; p++) begin : gen_pos
        logic [W-1:0] mem [DEPTH];
        logic [W-1:0] rd_q;
        logic         pres_q;

        // image write port and registered read for this position
        always_ff @(posedge clk) begin
            if (byte_we && (wr_pos == PW'(p))) mem[wr_addr] <= wr_data;
            rd_q <= mem[rd_addr];
        end

        // presence flag for this position
        always_ff @(posedge clk) begin
            if (!rst_n)                                 pres_q <= 1'b0;
            else if (pres_we && (wr_pos == PW'(p)))     pres_q <= wr_data[0];
        end

        assign rd_all[p]  = rd_q;
        assign present[p] = pres_q;
    end

    assign rd_data = rd_all[rd_pos];
endmodule

// File: rtl/spi_eep_ctrl.sv
// Holds the select register, decodes the target by priority, latches it
// per frame, tracks the read address and chooses each reply byte.
// Assumes two card positions and a four-byte frame.
module spi_eep_ctrl
    import spi_eep_pkg::*;
#(
    parameter int W      = 8,
    parameter int AW     = 7,
    parameter int BW     = 3,
    parameter int SEL_HI = 5,
    parameter int SEL_LO = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_we,
    input  logic [W-1:0]  sel_wdata,
    input  logic          cs_start,
    input  logic          rx_done,
    input  logic [BW-1:0] rx_idx,
    input  logic [W-1:0]  rx_byte,
    input  logic [BW-1:0] load_idx,
    input  logic [1:0]    present,
    input  logic [W-1:0]  rd_data,
    output logic [W-1:0]  tx_first,
    output logic [W-1:0]  tx_next,
    output logic          rd_pos,
    output logic [AW-1:0] rd_addr,
    output logic          err_pulse,
    output logic [W-1:0]  sel_q,
    output target_t       tgt
);
    target_t pick;
    logic    hit_now;
    logic    unused_hi;

    // priority decode of the two select bits
    always_comb begin
        pick = '0;
        if (sel_q[SEL_HI])      pick = '{ok: 1'b1, pos: 1'b0};
        else if (sel_q[SEL_LO]) pick = '{ok: 1'b1, pos: 1'b1};
    end

    assign hit_now  = pick.ok && present[pick.pos];
    assign tx_first = hit_now ? '0 : '1;
    assign rd_pos   = tgt.pos;
    assign unused_hi = ^rx_byte[W-1:AW];

    // select register written between frames
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_we) sel_q <= sel_wdata;
    end

    // latch the target and flag an unusable select at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt       <= '0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= cs_start && !pick.ok;
            if (cs_start) tgt <= '{ok: hit_now, pos: pick.pos};
        end
    end

    // read address: offset on byte 1, next address on byte 2
    always_ff @(posedge clk) begin
        if (!rst_n) rd_addr <= '0;
        else if (rx_done && (rx_idx == BW'(1))) rd_addr <= rx_byte[AW-1:0];
        else if (rx_done && (rx_idx == BW'(2))) rd_addr <= rd_addr + 1'b1;
    end

    // reply byte for the next byte time
    always_comb begin
        case (load_idx)
            BW'(0), BW'(1): tx_next = tgt.ok ? '0 : '1;
            BW'(2), BW'(3): tx_next = tgt.ok ? rd_data : '1;
            default:        tx_next = '1;
        endcase
    end
endmodule

// File: rtl/spi_eep_responder.sv
// Top level of the card identity SPI read responder: synchronisers,
// byte engine, control and image store, plus a load port gated to idle.
// Assumes the SPI clock is at least 16x slower than clk.
module spi_eep_responder
    import spi_eep_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 128,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_HI_BIT  = 5,
    parameter int SEL_LO_BIT  = 3,
    localparam int AW         = $clog2(DEPTH),
    localparam int BW         = $clog2(FRAME_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              ld_en,
    input  logic [1:0]        ld_kind,
    input  logic              ld_pos,
    input  logic [AW-1:0]     ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              err_pulse
);
    logic              sclk_rise, sclk_fall, cs_start, cs_low, mosi_s;
    logic              miso_bit, rx_done;
    logic [DATA_W-1:0] rx_byte, tx_first, tx_next, rd_data, sel_q;
    logic [BW-1:0]     rx_idx, load_idx;
    logic [1:0]        present;
    logic              rd_pos;
    logic [AW-1:0]     rd_addr;
    target_t           tgt;
    logic              ld_ok;
    ld_kind_e          kind;

    assign kind  = ld_kind_e'(ld_kind);
    assign ld_ok = ld_en && spi_cs_n && !cs_low;

    spi_eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_raw(spi_sclk), .cs_n_raw(spi_cs_n), .mosi_raw(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_start(cs_start), .cs_low(cs_low), .mosi_s(mosi_s)
    );

    spi_eep_shift #(.W(DATA_W), .FRAME(FRAME_BYTES)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_start(cs_start), .cs_low(cs_low), .mosi(mosi_s),
        .tx_first(tx_first), .tx_next(tx_next),
        .miso_bit(miso_bit), .rx_done(rx_done), .rx_byte(rx_byte),
        .rx_idx(rx_idx), .load_idx(load_idx)
    );

    spi_eep_ctrl #(
        .W(DATA_W), .AW(AW), .BW(BW),
        .SEL_HI(SEL_HI_BIT), .SEL_LO(SEL_LO_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sel_we(ld_ok && (kind == LD_SEL)), .sel_wdata(ld_data),
        .cs_start(cs_start), .rx_done(rx_done), .rx_idx(rx_idx),
        .rx_byte(rx_byte), .load_idx(load_idx), .present(present),
        .rd_data(rd_data), .tx_first(tx_first), .tx_next(tx_next),
        .rd_pos(rd_pos), .rd_addr(rd_addr), .err_pulse(err_pulse),
        .sel_q(sel_q), .tgt(tgt)
    );

    spi_eep_store #(.W(DATA_W), .DEPTH(DEPTH), .POS(2)) u_store (
        .clk(clk), .rst_n(rst_n),
        .byte_we(ld_ok && (kind == LD_BYTE)),
        .pres_we(ld_ok && (kind == LD_PRES)),
        .wr_pos(ld_pos), .wr_addr(ld_addr), .wr_data(ld_data),
        .rd_pos(rd_pos), .rd_addr(rd_addr), .rd_data(rd_data),
        .present(present)
    );

    assign spi_miso = miso_bit | ~cs_low;
endmodule

// File: rtl/spi_eep_check.sv
// Property checker for the responder, attached by bind below.
// Assumes it sees the top's ports and a few control-path signals.
module spi_eep_check #(
    parameter int W  = 8,
    parameter int BW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          spi_cs_n,
    input logic          spi_miso,
    input logic          err_pulse,
    input logic          cs_low,
    input logic [W-1:0]  sel_q,
    input logic [BW-1:0] load_idx,
    input logic [1:0]    tgt
);
    // R11: an idle link holds the reply line high
    assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> spi_miso);

    // R9: the error strobe lasts one clock
    assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    // R9: the error strobe only follows a select with neither decode bit
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (!sel_q[5] && !sel_q[3]));

    // R2: the byte counter never runs past the frame length
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_idx <= BW'(4));

    // R10: the latched target holds for the whole frame
    assert_target_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_low, 2) && $past(cs_low) && cs_low) |-> $stable(tgt));

    // R10: the select register cannot change inside a frame
    assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_low) && cs_low) |-> $stable(sel_q));
endmodule

bind spi_eep_responder spi_eep_check #(.W(DATA_W), .BW(BW)) u_check (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .err_pulse(err_pulse), .cs_low(cs_low), .sel_q(sel_q),
    .load_idx(load_idx), .tgt(tgt)
);

// File: tb/tb_spi_eep_responder.sv
// Self-checking bench: a behavioural model of images, presence flags and
// the select register predicts every reply byte and error pulse.
module tb_spi_eep_responder;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic       ld_en = 1'b0;
    logic [1:0] ld_kind = 2'd3;
    logic       ld_pos = 1'b0;
    logic [6:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       err_pulse;

    int checks = 0, fails = 0, err_seen = 0, cycles = 0;
    int m_mem [2][128];
    int m_pres [2];
    int m_sel = 0;
    logic [7:0] got [4];

    always #10 clk = ~clk;

    spi_eep_responder dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .ld_en(ld_en),
        .ld_kind(ld_kind), .ld_pos(ld_pos), .ld_addr(ld_addr),
        .ld_data(ld_data), .err_pulse(err_pulse)
    );

    always @(negedge clk) if (err_pulse) err_seen++;

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            summary();
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic load(int kind, int pos, int addr, int data, bit model);
        @(negedge clk);
        ld_en = 1'b1; ld_kind = kind[1:0]; ld_pos = pos[0];
        ld_addr = addr[6:0]; ld_data = data[7:0];
        @(negedge clk);
        ld_en = 1'b0; ld_kind = 2'd3;
        if (model) begin
            if (kind == 0) m_mem[pos][addr] = data;
            else if (kind == 1) m_pres[pos] = data & 1;
            else if (kind == 2) m_sel = data;
        end
    endtask

    // send one byte and capture the reply byte
    task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    // one four-byte frame, compared against the model
    task automatic frame(string req, int cmd, int off);
        int exp [4];
        int pos;
        bit valid;
        int e0;
        valid = 1'b0; pos = 0;
        if (m_sel & 32'h20)      begin valid = 1'b1; pos = 0; end
        else if (m_sel & 32'h08) begin valid = 1'b1; pos = 1; end
        if (valid && m_pres[pos] != 0) begin
            exp[0] = 0; exp[1] = 0;
            exp[2] = m_mem[pos][off & 127];
            exp[3] = m_mem[pos][(off + 1) & 127];
        end else begin
            exp = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
        end
        e0 = err_seen;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        xfer_byte(cmd[7:0], got[0]);
        xfer_byte(off[7:0], got[1]);
        xfer_byte(8'h00, got[2]);
        xfer_byte(8'h00, got[3]);
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        for (int i = 0; i < 4; i++) check(req, got[i], exp[i]);
        check({req, " R9 err count"}, err_seen - e0, valid ? 0 : 1);
        check({req, " R11 idle miso"}, spi_miso, 1);
    endtask

    initial begin
        logic [7:0] junk;
        m_pres = '{0, 0};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state at the ports
        check("R1 miso", spi_miso, 1);
        check("R1 err", err_pulse, 0);
        for (int p = 0; p < 2; p++)
            for (int a = 0; a < 128; a++)
                load(0, p, a, (a * 7 + p * 64 + 3) & 255, 1'b1);
        // R1/R4: select 0 and no presence after reset give an empty reply
        frame("R1 R4 reset select", 3, 5);
        load(1, 0, 0, 1, 1'b1);
        load(1, 1, 0, 1, 1'b1);
        load(2, 0, 0, 8'h20, 1'b1);
        frame("R5 R2 pos0 read", 3, 5);
        load(2, 0, 0, 8'h28, 1'b1);
        frame("R3 priority bit5", 3, 40);
        load(2, 0, 0, 8'h08, 1'b1);
        frame("R3 pos1", 3, 12);
        frame("R6 wrap 127", 3, 127);
        frame("R6 offset bit7", 3, 8'h85);
        frame("R7 command ignored", 8'hA7, 33);
        load(2, 0, 0, 8'h00, 1'b1);
        frame("R4 R9 no select", 3, 9);
        load(2, 0, 0, 8'hD7, 1'b1);
        frame("R4 R9 other bits only", 3, 9);
        load(2, 0, 0, 8'h08, 1'b1);
        load(1, 1, 0, 0, 1'b1);
        frame("R4 R10 absent pos1", 3, 9);
        load(1, 1, 0, 1, 1'b1);
        // R8: abandon a frame after ten bits, then read cleanly
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        xfer_byte(8'h03, junk);
        for (int b = 0; b < 2; b++) begin
            spi_mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        spi_cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        frame("R8 after abort", 3, 70);
        // R10: loads during a frame must be ignored
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        load(0, 1, 20, 8'h5A, 1'b0);
        load(2, 0, 0, 8'h00, 1'b0);
        load(1, 1, 0, 0, 1'b0);
        spi_cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        frame("R10 load in frame ignored", 3, 19);
        // R10: kind 3 does nothing
        load(3, 1, 20, 8'h00, 1'b0);
        frame("R10 kind none", 3, 20);
        load(0, 0, 0, 8'hC3, 1'b1);
        load(2, 0, 0, 8'h20, 1'b1);
        frame("R6 wrap pos0", 3, 127);
        summary();
    end
endmodule